// File: doc/BRIEF.md
# Critical-Word-First Data Cache Refill Controller

This block holds the lookup and refill state of a 16 KB, 4-way set associative data cache with 16-byte lines. The set is chosen from the untranslated word address in the cycle the load is issued. The translated physical tag comes one cycle later and is compared against the stored tags of that set. A hit returns its word at once.

On a miss the controller asks memory for the line and names the word the load wants. Memory returns the four words starting at that word and wrapping around the line. The stalled load is released in the cycle its own word arrives. The other three words are stored while later loads keep issuing. A load that touches the line still being filled gets its word if it has already arrived. Otherwise it waits for it. Only one refill is outstanding at a time.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: A load request is taken on a rising edge where `ld_stall` is low; `ld_widx[9:2]` selects the set and `ld_widx[1:0]` the word. `ld_ptag` must be valid from the following cycle and held while `ld_stall` is high. `ld_stall` stays high while that load is unresolved, and a request made during a stall is not taken.
- R2: A load whose line is valid in the set completes in the cycle after it was taken (`ld_valid` high, `ld_stall` low) with the stored word.
- R3: A load that misses while no refill runs raises `mem_req` for exactly that cycle, with `mem_line` = {physical tag, set}.
- R4: `mem_crit` carries the missed word number. Memory returns four words, one per `mem_wvalid` pulse, for word numbers crit, crit+1, crit+2, crit+3 modulo 4. Each word is stored at its own position in the line.
- R5: The missed load completes in the cycle its word is on `mem_wdata`, and it returns that value.
- R6: A load of the line being refilled whose word has already arrived completes at once. If its word arrives in that same cycle, the word is forwarded from `mem_wdata`.
- R7: A load that misses on a different line while a refill is running stalls without raising `mem_req`. It is looked up again after the refill's last word.
- R8: The refilled line is marked valid only after its fourth word. Until then, a load of a word of that line that has not yet arrived stalls.
- R9: The victim is the lowest-numbered invalid way of the set, or else the least recently used way. A hit and a completed refill each make their way the most recent. When a refill completes in the same cycle as a hit in the same set, the refill counts as the newer.
- R10: After reset every line is invalid, and `ld_stall`, `ld_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_req | input | 1 | Load request |
| ld_widx | input | 10 | Untranslated word address within the page: set and word |
| ld_ptag | input | 20 | Translated physical tag, one cycle after the request |
| ld_stall | output | 1 | Accepted load not yet resolved; hold inputs |
| ld_valid | output | 1 | Load data valid |
| ld_data | output | 32 | Load data |
| mem_req | output | 1 | Line request to memory, one cycle |
| mem_line | output | 28 | Physical line address {tag, set} |
| mem_crit | output | 2 | Word to return first |
| mem_wvalid | input | 1 | Refill word valid |
| mem_wdata | input | 32 | Refill word |

## Verification
Directed loads first cover one miss followed by loads of other words of the same line during the fill, a miss to another line during that fill, and five lines cycled through one set. Together these separate early restart, forwarding from stored words against forwarding from the bus, blocking of a second refill, and the choice of LRU victim. A long run then draws from four sets and six tags per set, with a random first-word latency and random gaps between refill words. This makes hits, conflict evictions and accesses to the line being filled land in every phase of a refill. A reference model compares the stall, completion, data and request outputs every cycle.

// File: rtl/cwf_pkg.sv
// Shared types for the critical-word-first refill controller.
// Assumes 32-bit data words throughout.
package cwf_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic {FILL_IDLE, FILL_BUSY} fill_st_e;
endpackage

// File: rtl/cwf_tag_cmp.sv
// Compares the translated tag with every way of one set.
// Assumes at most one valid way holds a given tag.
module cwf_tag_cmp #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 20,
    parameter int unsigned WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]           ptag,
    output logic [WAYS-1:0]            hit_oh,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit_oh[g] = valid[g] && (tags[g] == ptag);
    end

    // encode the matching way number
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_oh[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |hit_oh;
endmodule

// File: rtl/cwf_victim.sv
// Picks the way to replace: lowest invalid way, else the oldest way.
// Assumes the ages of a set form a permutation of 0..WAYS-1.
module cwf_victim #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age,
    input  logic [WAYS-1:0]            valid,
    output logic [WAY_W-1:0]           victim
);
    // invalid way first, else the way with the largest age
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/cwf_age_upd.sv
// Makes one way of a set the most recent and ages the ways that were newer.
// Assumes the ages form a permutation; the result is again a permutation.
module cwf_age_upd #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age,
    input  logic [WAY_W-1:0]           touch,
    output logic [WAYS-1:0][WAY_W-1:0] age_nxt
);
    for (genvar g = 0; g < WAYS; g++) begin : g_age
        assign age_nxt[g] = (WAY_W'(g) == touch)   ? '0 :
                            (age[g] < age[touch])  ? age[g] + 1'b1 : age[g];
    end
endmodule

// File: rtl/cwf_fill_seq.sv
// Tracks one refill: which word arrives next in wrap order and which have arrived.
// Assumes memory sends exactly LINE_WORDS words per request, only while busy.
module cwf_fill_seq #(
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned OFF_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [OFF_W-1:0]      start_crit,
    input  logic                  word_valid,
    output logic                  busy,
    output logic [OFF_W-1:0]      word_pos,
    output logic [LINE_WORDS-1:0] recv,
    output logic                  last
);
    import cwf_pkg::*;

    fill_st_e         st;
    logic [OFF_W-1:0] crit_q;
    logic [OFF_W-1:0] cnt;

    assign busy     = (st == FILL_BUSY);
    assign word_pos = crit_q + cnt;
    assign last     = busy && word_valid && (cnt == OFF_W'(LINE_WORDS - 1));

    // refill progress: start, count words, mark arrivals, finish on the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= FILL_IDLE;
            crit_q <= '0;
            cnt    <= '0;
            recv   <= '0;
        end else if (start) begin
            st     <= FILL_BUSY;
            crit_q <= start_crit;
            cnt    <= '0;
            recv   <= '0;
        end else if (busy && word_valid) begin
            recv[word_pos] <= 1'b1;
            cnt            <= cnt + 1'b1;
            if (last) st <= FILL_IDLE;
        end
    end

    // R4
    arrived_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(recv) == int'(cnt)));

    // R3
    word_in_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> busy);
endmodule

// File: rtl/cwf_refill_ctrl.sv
// Data cache lookup and critical-word-first refill controller.
// Virtually indexed, physically tagged; one load in the lookup stage and
// one refill outstanding. Assumes ld_ptag is held while ld_stall is high.
module cwf_refill_ctrl #(
    parameter  int unsigned CACHE_BYTES = 16384,
    parameter  int unsigned WAYS        = 4,
    parameter  int unsigned LINE_WORDS  = 4,
    parameter  int unsigned ADDR_W      = 32,
    localparam int unsigned LINE_BYTES  = LINE_WORDS * 4,
    localparam int unsigned SETS        = CACHE_BYTES / (WAYS * LINE_BYTES),
    localparam int unsigned IDX_W       = $clog2(SETS),
    localparam int unsigned OFF_W       = $clog2(LINE_WORDS),
    localparam int unsigned VA_W        = IDX_W + OFF_W,
    localparam int unsigned TAG_W       = ADDR_W - VA_W - 2,
    localparam int unsigned WAY_W       = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_req,
    input  logic [VA_W-1:0]               ld_widx,
    input  logic [TAG_W-1:0]              ld_ptag,
    output logic                          ld_stall,
    output logic                          ld_valid,
    output logic [cwf_pkg::WORD_W-1:0]    ld_data,
    output logic                          mem_req,
    output logic [TAG_W+IDX_W-1:0]        mem_line,
    output logic [OFF_W-1:0]              mem_crit,
    input  logic                          mem_wvalid,
    input  logic [cwf_pkg::WORD_W-1:0]    mem_wdata
);
    import cwf_pkg::*;

    // line storage
    logic [WAYS-1:0][TAG_W-1:0] tag_mem  [SETS];
    logic [WAYS-1:0]            vld_mem  [SETS];
    logic [WAYS-1:0][WAY_W-1:0] age_mem  [SETS];
    word_t                      data_mem [SETS][WAYS][LINE_WORDS];

    // lookup stage
    logic             s1_v;
    logic [IDX_W-1:0] s1_idx;
    logic [OFF_W-1:0] s1_off;

    // refill state
    logic                  fill_active, fill_last;
    logic [OFF_W-1:0]      fill_pos;
    logic [LINE_WORDS-1:0] fill_recv;
    logic [IDX_W-1:0]      fill_idx;
    logic [TAG_W-1:0]      fill_tag;
    logic [WAY_W-1:0]      fill_way;

    logic [WAYS-1:0]            hit_oh;
    logic                       hit_any;
    logic [WAY_W-1:0]           hit_way, victim, rd_way;
    logic [WAYS-1:0][WAY_W-1:0] age_hit, age_fill, age_fill_in;
    logic fill_match, word_now, fill_fwd, miss_start, same_set, hit_touch;

    cwf_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_cmp (
        .tags(tag_mem[s1_idx]), .valid(vld_mem[s1_idx]), .ptag(ld_ptag),
        .hit_oh(hit_oh), .hit(hit_any), .hit_way(hit_way)
    );

    cwf_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
        .age(age_mem[s1_idx]), .valid(vld_mem[s1_idx]), .victim(victim)
    );

    cwf_age_upd #(.WAYS(WAYS), .WAY_W(WAY_W)) i_age_hit (
        .age(age_mem[s1_idx]), .touch(hit_way), .age_nxt(age_hit)
    );

    cwf_age_upd #(.WAYS(WAYS), .WAY_W(WAY_W)) i_age_fill (
        .age(age_fill_in), .touch(fill_way), .age_nxt(age_fill)
    );

    cwf_fill_seq #(.LINE_WORDS(LINE_WORDS), .OFF_W(OFF_W)) i_fill (
        .clk(clk), .rst_n(rst_n), .start(miss_start), .start_crit(s1_off),
        .word_valid(mem_wvalid), .busy(fill_active), .word_pos(fill_pos),
        .recv(fill_recv), .last(fill_last)
    );

    // resolve the load in the lookup stage: hit, forward from refill, or miss
    always_comb begin
        fill_match = fill_active && (s1_idx == fill_idx) && (ld_ptag == fill_tag);
        word_now   = mem_wvalid && (fill_pos == s1_off);
        fill_fwd   = fill_match && (fill_recv[s1_off] || word_now);
        ld_valid   = s1_v && (hit_any || fill_fwd);
        ld_stall   = s1_v && !ld_valid;
        miss_start = s1_v && !hit_any && !fill_match && !fill_active;
        rd_way     = fill_match ? fill_way : hit_way;
        ld_data    = (fill_match && !fill_recv[s1_off]) ? mem_wdata
                                                        : data_mem[s1_idx][rd_way][s1_off];
        same_set    = (fill_idx == s1_idx);
        hit_touch   = ld_valid && hit_any;
        age_fill_in = (hit_touch && same_set) ? age_hit : age_mem[fill_idx];
    end

    assign mem_req  = miss_start;
    assign mem_line = {ld_ptag, s1_idx};
    assign mem_crit = s1_off;

    // take a new load into the lookup stage whenever not stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_idx <= '0;
            s1_off <= '0;
        end else if (!ld_stall) begin
            s1_v   <= ld_req;
            s1_idx <= ld_widx[VA_W-1:OFF_W];
            s1_off <= ld_widx[OFF_W-1:0];
        end
    end

    // remember where the current refill goes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_idx <= '0;
            fill_tag <= '0;
            fill_way <= '0;
        end else if (miss_start) begin
            fill_idx <= s1_idx;
            fill_tag <= ld_ptag;
            fill_way <= victim;
        end
    end

    // valid bits and recency: drop victim on start, validate on last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_mem[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_mem[s][w] <= WAY_W'(w);
            end
        end else begin
            if (miss_start) vld_mem[s1_idx][victim] <= 1'b0;
            if (fill_last) begin
                vld_mem[fill_idx][fill_way] <= 1'b1;
                age_mem[fill_idx]           <= age_fill;
            end
            if (hit_touch && !(fill_last && same_set)) age_mem[s1_idx] <= age_hit;
        end
    end

    // tag write at refill start, data write per arriving word
    always_ff @(posedge clk) begin
        if (miss_start) tag_mem[s1_idx][victim] <= ld_ptag;
        if (fill_active && mem_wvalid) data_mem[fill_idx][fill_way][fill_pos] <= mem_wdata;
    end

    // R3
    refill_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> fill_active);

    // R1
    load_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |=> (s1_v && $stable(s1_idx) && $stable(s1_off)));

    // R8
    fill_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_active |-> !vld_mem[fill_idx][fill_way]);

    // R8
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |=> vld_mem[fill_idx][fill_way]);

    // R9
    single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |-> $onehot0(hit_oh));
endmodule

// File: tb/test_cwf_refill_ctrl.sv
`timescale 1ns/1ps
module test_cwf_refill_ctrl;
    localparam int ND    = 14;
    localparam int TOTAL = ND + 3000;

    logic        clk = 1'b0, rst_n = 1'b0, ld_req = 1'b0, mem_wvalid = 1'b0;
    logic [9:0]  ld_widx = '0;
    logic [19:0] ld_ptag = '0;
    logic [31:0] mem_wdata = '0;
    logic        ld_stall, ld_valid, mem_req;
    logic [31:0] ld_data;
    logic [27:0] mem_line;
    logic [1:0]  mem_crit;

    cwf_refill_ctrl i_cwf_refill_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_widx(ld_widx), .ld_ptag(ld_ptag),
        .ld_stall(ld_stall), .ld_valid(ld_valid), .ld_data(ld_data),
        .mem_req(mem_req), .mem_line(mem_line), .mem_crit(mem_crit),
        .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata)
    );

    always #2 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int unsigned seed = 32'h1234_5678;

    // reference state: resident tags per set, most recent first
    int res_q [256][$];
    bit o_v = 0;      int o_set, o_off, o_tag;
    bit f_busy = 0;   int f_set, f_tag, f_crit, f_cnt; bit [3:0] f_recv;
    bit m_busy = 0;   int m_k, m_wait;
    bit have_nxt = 0; int nxt_set, nxt_off, nxt_tag; int issued = 0;

    int d_set [ND] = '{5, 5, 5, 5, 5, 9, 9, 9, 9, 9, 9, 9, 9, 255};
    int d_tag [ND] = '{1, 1, 1, 2, 1, 10, 11, 12, 13, 10, 14, 11, 10, 3};
    int d_off [ND] = '{2, 3, 0, 1, 1, 0, 0, 0, 0, 1, 0, 3, 2, 3};

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic logic [31:0] memf(int t, int s, int p);
        logic [31:0] a;
        a = 32'((t << 12) | (s << 4) | (p << 2));
        return (a * 32'h9E37_79B1) ^ 32'h3C5A_0F96;
    endfunction

    function automatic bit resident(int s, int t);
        foreach (res_q[s][i]) if (res_q[s][i] == t) return 1'b1;
        return 1'b0;
    endfunction

    task automatic touch(int s, int t);
        for (int i = 0; i < res_q[s].size(); i++) begin
            if (res_q[s][i] == t) begin
                res_q[s].delete(i);
                break;
            end
        end
        res_q[s].push_front(t);
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    initial begin
        int cyc;
        bit exp_res, fill_m, exp_fwd, exp_valid, exp_req, accepted;
        int cur_pos;
        string tg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(ld_stall == 1'b0, "R10", "ld_stall after reset", ld_stall, 0);
        chk(ld_valid == 1'b0, "R10", "ld_valid after reset", ld_valid, 0);
        chk(mem_req  == 1'b0, "R10", "mem_req after reset", mem_req, 0);
        cyc = 0;
        while (!(issued == TOTAL && !o_v && !m_busy && !f_busy)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "R1", "watchdog expired", cyc, 150000);
                break;
            end
            // memory: deliver refill words in wrap order with random gaps (R4)
            mem_wvalid = 1'b0;
            cur_pos    = -1;
            if (m_busy) begin
                if (m_wait == 0) begin
                    cur_pos    = (f_crit + m_k) % 4;
                    mem_wvalid = 1'b1;
                    mem_wdata  = memf(f_tag, f_set, cur_pos);
                    m_k++;
                    m_wait = int'(rnd() % 3);
                    if (m_k == 4) m_busy = 1'b0;
                end else m_wait--;
            end
            // load source
            if (o_v) ld_ptag = 20'(o_tag);
            if (!have_nxt && issued < TOTAL) begin
                if (issued < ND) begin
                    nxt_set = d_set[issued]; nxt_tag = d_tag[issued]; nxt_off = d_off[issued];
                end else begin
                    case (rnd() % 4)
                        0: nxt_set = 0;
                        1: nxt_set = 1;
                        2: nxt_set = 77;
                        default: nxt_set = 255;
                    endcase
                    nxt_tag = 100 + int'(rnd() % 6);
                    nxt_off = int'(rnd() % 4);
                end
                have_nxt = 1'b1;
            end
            ld_req  = have_nxt;
            ld_widx = 10'(nxt_set * 4 + nxt_off);
            #1;
            // expected outputs this cycle
            exp_res   = o_v && resident(o_set, o_tag);
            fill_m    = o_v && f_busy && f_set == o_set && f_tag == o_tag;
            exp_fwd   = fill_m && (f_recv[o_off] || (mem_wvalid && cur_pos == o_off));
            exp_valid = exp_res || exp_fwd;
            exp_req   = o_v && !exp_res && !fill_m && !f_busy;
            if (exp_res) tg = "R2";
            else if (fill_m && f_recv[o_off]) tg = "R6";
            else if (exp_fwd) tg = "R5";
            else if (fill_m) tg = "R8";
            else if (o_v) tg = "R7";
            else tg = "R1";
            chk(ld_valid == exp_valid, tg, "ld_valid", ld_valid, exp_valid);
            if (ld_valid && exp_valid)
                chk(ld_data == memf(o_tag, o_set, o_off), exp_res ? "R2" : "R4",
                    "ld_data", ld_data, memf(o_tag, o_set, o_off));
            chk(ld_stall == (o_v && !exp_valid), "R1", "ld_stall", ld_stall, o_v && !exp_valid);
            if (exp_req) tg = "R3";
            else if (o_v && f_busy && !exp_res && !fill_m) tg = "R7";
            else tg = "R9";
            chk(mem_req == exp_req, tg, "mem_req", mem_req, exp_req);
            if (mem_req && exp_req) begin
                chk(mem_line == 28'(o_tag * 256 + o_set), "R3", "mem_line",
                    mem_line, o_tag * 256 + o_set);
                chk(mem_crit == 2'(o_off), "R4", "mem_crit", mem_crit, o_off);
            end
            // advance the reference
            accepted = ld_req && !ld_stall;
            if (exp_valid) begin
                if (exp_res) touch(o_set, o_tag);
                o_v = 1'b0;
            end
            if (mem_wvalid) begin
                f_recv[cur_pos] = 1'b1;
                f_cnt++;
                if (f_cnt == 4) begin
                    f_busy = 1'b0;
                    res_q[f_set].push_front(f_tag);
                end
            end
            if (exp_req) begin
                if (res_q[o_set].size() == 4) void'(res_q[o_set].pop_back());
                f_busy = 1'b1; f_set = o_set; f_tag = o_tag; f_crit = o_off;
                f_cnt = 0; f_recv = '0;
                m_busy = 1'b1; m_k = 0; m_wait = int'(rnd() % 4);
            end
            if (accepted) begin
                o_v = 1'b1; o_set = nxt_set; o_tag = nxt_tag; o_off = nxt_off;
                have_nxt = 1'b0;
                issued++;
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule